// File: doc/BRIEF.md
# Recursive Quadratic-Permutation Address Generator

This block produces, one per clock, the interleaved addresses that a turbo code block of length K needs. The permutation is the quadratic polynomial pi(x) = (f1*x + f2*x^2) mod K. It is never evaluated directly. Each address comes from the one before it, through a running first difference g(x). The difference itself moves by the constant 2*f2 mod K on every step.

Each update is one add followed by at most one subtraction of K, so the block needs no multiplier and keeps no address table. The encoder and the decoder can each own an instance. A start strobe loads K, f1 and f2, and the block switches to a new length in the same cycle. An advance input then steps through indices 0 to K-1. A last flag marks the final index, and the block goes idle once that address is consumed.

The caller must supply 40 <= K <= 6144, f1 < K and f2 < K, together with a coefficient pair that makes the polynomial a permutation of 0..K-1.

Top module: `qpp_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, addrValid and addrLast are 0 and addrOut is 0 until the first start.
- R2: In the cycle after start is sampled high, addrValid is 1 and addrOut is 0, which is index 0.
- R3: While addrValid is 1, addrOut equals (f1*x + f2*x*x) mod K for the current index x. The index increases by one at each clock edge where advance is sampled high.
- R4: At a clock edge where addrValid is 1 and both advance and start are low, the index and addrOut do not change.
- R5: addrLast is 1 exactly when addrValid is 1 and the index is K-1.
- R6: An advance sampled high while addrLast is 1 drops addrValid in the next cycle. addrValid then stays 0 whatever advance does, until the next start.
- R7: start takes priority over advance and restarts the sequence from index 0 with the new K, f1 and f2, even in the middle of a run.
- R8: For any K from 40 to 6144 with permutation coefficients, the K addresses of one run are all different and together cover 0..K-1.
- R9: Every address shown with addrValid high is below K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Loads lenIn, coefF1In and coefF2In and restarts the sequence |
| lenIn | input | 13 | Block length K, sampled at start |
| coefF1In | input | 13 | Linear coefficient f1, sampled at start |
| coefF2In | input | 13 | Quadratic coefficient f2, sampled at start |
| advance | input | 1 | Consume the current address and step to the next index |
| addrOut | output | 13 | Current interleaved address |
| addrValid | output | 1 | addrOut holds an address of the active run |
| addrLast | output | 1 | The current index is K-1 |

## Verification
Every result comes out of a register, so each one is due one clock after the edge that sampled its cause. This covers address 0 after start, the next address after advance, the held address after an idle cycle, and the fall of addrValid after the final advance. The bench drives inputs on the falling edge and steps its behavioural model at the rising edge. It compares addrOut, addrValid and addrLast on the following falling edge, which is where the one-register latency puts the new values. Each address is consumed in the same cycle it is checked, and the consumed addresses are recorded to confirm that every run covers 0..K-1 with no repeat.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  // 13 bits covers block lengths up to 8191, so 6144 fits
  parameter int unsigned ADDR_W = 13;

  // strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic load;   // latch length and coefficients, seed the recursion
    logic step;   // move address and difference one index forward
  } qppStrobe_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } qppSeq_e;
endpackage

// File: rtl/qpp_modadd.sv
// (opA + opB) mod modulus for operands already below modulus:
// one add and a single conditional subtract.
module qpp_modadd #(
  parameter int unsigned W = 13
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] result
);
  localparam int unsigned SUM_W = W + 1;

  logic [SUM_W-1:0] rawSum;
  logic [SUM_W-1:0] modExt;

  always_comb begin
    rawSum = {1'b0, opA} + {1'b0, opB};
    modExt = {1'b0, modulus};
    if (rawSum >= modExt) begin
      result = W'(rawSum - modExt);
    end else begin
      result = W'(rawSum);
    end
  end
endmodule

// File: rtl/qpp_datapath.sv
module qpp_datapath
  import qpp_pkg::*;
#(
  parameter int unsigned W = ADDR_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  qppStrobe_t strobe,
  input  logic [W-1:0] lenIn,
  input  logic [W-1:0] coefF1In,
  input  logic [W-1:0] coefF2In,
  output logic [W-1:0] lenQ,
  output logic [W-1:0] addrQ
);
  logic [W-1:0] diffQ;      // g(x)
  logic [W-1:0] incQ;       // 2*f2 mod K
  logic [W-1:0] seedInc;
  logic [W-1:0] seedDiff;
  logic [W-1:0] nextAddr;
  logic [W-1:0] nextDiff;

  // seeds computed from the raw inputs against the incoming length
  qpp_modadd #(.W(W)) u_seedInc (
    .opA(coefF2In), .opB(coefF2In), .modulus(lenIn), .result(seedInc)
  );
  qpp_modadd #(.W(W)) u_seedDiff (
    .opA(coefF1In), .opB(coefF2In), .modulus(lenIn), .result(seedDiff)
  );

  // running recursion against the latched length
  qpp_modadd #(.W(W)) u_stepAddr (
    .opA(addrQ), .opB(diffQ), .modulus(lenQ), .result(nextAddr)
  );
  qpp_modadd #(.W(W)) u_stepDiff (
    .opA(diffQ), .opB(incQ), .modulus(lenQ), .result(nextDiff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenQ  <= '0;
      incQ  <= '0;
      diffQ <= '0;
      addrQ <= '0;
    end else if (strobe.load) begin
      lenQ  <= lenIn;
      incQ  <= seedInc;
      diffQ <= seedDiff;
      addrQ <= '0;
    end else if (strobe.step) begin
      addrQ <= nextAddr;
      diffQ <= nextDiff;
    end
  end
endmodule

// File: rtl/qpp_ctrl.sv
module qpp_ctrl
  import qpp_pkg::*;
#(
  parameter int unsigned W = ADDR_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       advance,
  input  logic [W-1:0] lenQ,
  output qppStrobe_t strobe,
  output logic       validOut,
  output logic       lastOut
);
  qppSeq_e     seqQ;
  logic [W-1:0] idxQ;
  logic        atFinal;

  assign validOut = (seqQ == SEQ_RUN);
  assign atFinal  = validOut && (idxQ == (lenQ - W'(1)));
  assign lastOut  = atFinal;

  always_comb begin
    strobe.load = start;
    strobe.step = !start && validOut && advance && !atFinal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqQ <= SEQ_IDLE;
      idxQ <= '0;
    end else if (start) begin
      seqQ <= SEQ_RUN;
      idxQ <= '0;
    end else if (validOut && advance) begin
      if (atFinal) begin
        seqQ <= SEQ_IDLE;
      end else begin
        idxQ <= idxQ + W'(1);
      end
    end
  end
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
  import qpp_pkg::*;
#(
  parameter int unsigned W = ADDR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] lenIn,
  input  logic [W-1:0] coefF1In,
  input  logic [W-1:0] coefF2In,
  input  logic         advance,
  output logic [W-1:0] addrOut,
  output logic         addrValid,
  output logic         addrLast
);
  qppStrobe_t   strobe;
  logic [W-1:0] lenQ;

  qpp_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .lenQ(lenQ), .strobe(strobe), .validOut(addrValid), .lastOut(addrLast)
  );

  qpp_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .lenIn(lenIn),
    .coefF1In(coefF1In), .coefF2In(coefF2In), .lenQ(lenQ), .addrQ(addrOut)
  );
endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk #(
  parameter int unsigned W = 13
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         advance,
  input logic [W-1:0] lenQ,
  input logic [W-1:0] addrOut,
  input logic         addrValid,
  input logic         addrLast
);
  // R2: start gives index 0 next cycle
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addrValid && addrOut == '0));

  // R4: no advance, no start -> address held
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addrValid && !advance && !start) |=> (addrValid && $stable(addrOut)));

  // R5: last only while valid
  a_r5_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    addrLast |-> addrValid);

  // R6: consuming the last address ends the run
  a_r6_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (addrLast && advance && !start) |=> !addrValid);

  // R6: idle stays idle without start
  a_r6_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!addrValid && !start) |=> !addrValid);

  // R9: address below the latched length
  a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid |-> (addrOut < lenQ));
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
  .lenQ(lenQ), .addrOut(addrOut), .addrValid(addrValid), .addrLast(addrLast)
);

// File: tb/sim_qpp_addr_gen.sv
module sim_qpp_addr_gen;
  localparam int W = 13;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         advance;
  logic [W-1:0] lenIn;
  logic [W-1:0] coefF1In;
  logic [W-1:0] coefF2In;
  logic [W-1:0] addrOut;
  logic         addrValid;
  logic         addrLast;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  bit     mValid = 0;
  longint mIdx = 0;
  longint mK = 0;
  longint mF1 = 0;
  longint mF2 = 0;
  bit     seen [0:8191];
  int     consumed = 0;
  bit     holdPending = 0;
  logic [W-1:0] heldAddr = '0;

  qpp_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .lenIn(lenIn),
    .coefF1In(coefF1In), .coefF2In(coefF2In), .advance(advance),
    .addrOut(addrOut), .addrValid(addrValid), .addrLast(addrLast)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic longint refAddr(longint x);
    return (mF1 * x + mF2 * x * x) % mK;
  endfunction

  task automatic compareOutputs();
    check(addrValid == mValid, "R6 valid", addrValid, mValid);
    check(addrLast == (mValid && mIdx == mK - 1), "R5 last", addrLast,
          (mValid && mIdx == mK - 1));
    if (mValid) begin
      check(addrOut == refAddr(mIdx), "R3 address", addrOut, refAddr(mIdx));
      check(addrOut < mK, "R9 range", addrOut, mK);
    end
    if (holdPending && mValid) begin
      check(addrOut == heldAddr, "R4 hold", addrOut, heldAddr);
    end
  endtask

  // one clock: drive at the falling edge, model steps at rising edge,
  // compare at the next falling edge
  task automatic tick(input bit st, input bit adv);
    start   = st;
    advance = adv;
    if (addrValid && adv && !st) begin
      if (addrOut < 8192) begin
        if (seen[addrOut]) check(1'b0, "R8 duplicate", addrOut, -1);
        seen[addrOut] = 1'b1;
      end
      consumed++;
    end
    holdPending = addrValid && !adv && !st;
    heldAddr    = addrOut;
    @(posedge clk);
    if (st) begin
      mValid = 1; mIdx = 0;
      mK = lenIn; mF1 = coefF1In; mF2 = coefF2In;
    end else if (mValid && adv) begin
      if (mIdx == mK - 1) mValid = 0;
      else mIdx++;
    end
    @(negedge clk);
    compareOutputs();
  endtask

  task automatic startRun(input int k, input int f1, input int f2);
    lenIn = W'(k); coefF1In = W'(f1); coefF2In = W'(f2);
    for (int i = 0; i < 8192; i++) seen[i] = 1'b0;
    consumed = 0;
    tick(1'b1, 1'b0);
    // R2: index 0 right after start
    check(addrValid && addrOut == 0, "R2 start", addrOut, 0);
  endtask

  task automatic finishRun(input int gapMod);
    int n = 0;
    while (mValid && n < 20000) begin
      tick(1'b1 == 1'b0, (gapMod == 0) ? 1'b1 : ((n % gapMod) != 1));
      n++;
    end
    // R8: full permutation of 0..K-1
    check(consumed == mK, "R8 count", consumed, mK);
    begin
      int covered = 0;
      for (int i = 0; i < 8192; i++) if (seen[i]) covered++;
      check(covered == mK, "R8 coverage", covered, mK);
    end
    // R6: advance while idle has no effect
    for (int j = 0; j < 3; j++) tick(1'b0, 1'b1);
    check(addrValid == 1'b0 && addrLast == 1'b0, "R6 idle", addrValid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; advance = 1'b0;
    lenIn = '0; coefF1In = '0; coefF2In = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(addrValid == 0 && addrLast == 0 && addrOut == 0, "R1 reset",
          addrOut, 0);
    rst_n = 1'b1;
    @(negedge clk);
    tick(1'b0, 1'b1);
    check(addrValid == 0 && addrOut == 0, "R1 after release", addrValid, 0);

    startRun(40, 3, 10);     finishRun(0);
    startRun(48, 7, 12);     finishRun(3);
    startRun(512, 31, 64);   finishRun(5);

    // R7: restart in the middle of a run with new parameters
    startRun(1024, 31, 64);
    for (int i = 0; i < 25; i++) tick(1'b0, 1'b1);
    startRun(40, 3, 10);
    check(addrValid && addrOut == 0, "R7 restart", addrOut, 0);
    finishRun(4);

    // R7: start wins over advance in the same cycle
    startRun(48, 7, 12);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1);
    lenIn = W'(40); coefF1In = W'(3); coefF2In = W'(10);
    for (int i = 0; i < 8192; i++) seen[i] = 1'b0;
    consumed = 0;
    tick(1'b1, 1'b1);
    check(addrValid && addrOut == 0, "R7 start priority", addrOut, 0);
    finishRun(0);

    startRun(1024, 31, 64);  finishRun(7);
    startRun(6144, 263, 480); finishRun(0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule